// File: doc/BRIEF.md
# Trigger-Armed External-Edge Counter

This block is an up-counter whose increments come from edges on an asynchronous external clock pin instead of from the system clock. It stays idle until a trigger edge arrives on one of eight asynchronous trigger pins, selected by a code. When that edge comes in while trigger mode is selected, the run bit is set and the trigger flag is raised in the same cycle. From then on, every active external edge, after an optional division, advances the count. The count wraps to zero at a programmable limit.

Both the external clock pin and the trigger pins are brought into the system clock domain by a two-flop synchronizer followed by an edge detector. A pin edge therefore takes effect three system clocks after it occurs. Software drives a small write-only register port with four addresses:

- Address 0 is the mode word.
- Address 1 is the control word, with the run bit at bit 0.
- Address 2 is the wrap limit.
- Address 3 is the status word, with the flag at bit 0.

The mode word packs these fields:

| Bits | Field |
|------|-------|
| [2:0] | Slave-mode code |
| [5:3] | Trigger select |
| [6] | External-edge polarity |
| [8:7] | Prescaler code |
| [9] | External-edge enable |
| [10] | Trigger polarity |

Top module: `trig_ext_counter`

## Requirements
- R1: After a synchronous reset, the count is 0, the run bit is 0 and the trigger flag is 0.
- R2: With slave-mode code 110, an active edge on the selected trigger pin sets both the run bit and the flag. Both outputs change three system clocks after the pin edge and not earlier.
- R3: Trigger select code k (mode bits [5:3]) makes trig_pins[k] the only trigger source. Edges on the other trigger pins change neither the run bit nor the flag.
- R4: Trigger polarity (mode bit 10) set to 0 makes only rising edges act as triggers. Set to 1, it makes only falling edges act as triggers.
- R5: With any slave-mode code other than 110, trigger edges change neither the run bit nor the flag.
- R6: With the external-edge enable (mode bit 9) set and the run bit set, the count advances once per active edge of ext_clk_pin, three system clocks after that edge. External polarity (mode bit 6) selects the active edge: 0 for rising, 1 for falling. Inactive edges leave the count unchanged.
- R7: Prescaler codes 00, 01, 10 and 11 (mode bits [8:7]) pass one count per 1, 2, 4 and 8 active external edges respectively. The division phase restarts while the run bit is 0.
- R8: On a count event, a count that has reached or passed the wrap limit becomes 0. Otherwise it increases by one.
- R9: With the external-edge enable clear and the run bit set, the count advances once per system clock.
- R10: Writing 0 to status bit 0 clears the flag, and writing 1 leaves it unchanged. A trigger event in the same cycle as a clearing write leaves the flag set.
- R11: Once set, the run bit stays set until software writes 0 to control bit 0. While the run bit is 0, the count holds.
- R12: With the external-edge enable set and slave-mode code 001, 010, 011 or 111, the count holds whatever the external pin does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address (0 mode, 1 control, 2 wrap limit, 3 status) |
| cfg_wdata | input | CNT_W | Register write data |
| ext_clk_pin | input | 1 | Asynchronous external count pin |
| trig_pins | input | 8 | Asynchronous trigger pins |
| count_o | output | CNT_W | Current count |
| run_o | output | 1 | Run bit |
| trig_flag_o | output | 1 | Trigger-event flag |

## Verification
The hardest case to reach is a trigger edge that lands in exactly the same system clock as a software write clearing the flag. The bench reaches it by changing the trigger pin on a falling clock edge and then issuing the clearing write two cycles later, so that the write is captured on the same rising edge where the synchronized trigger takes effect. Divided external counting is also hard to observe, because phase and wrap interact. Random rounds cover it with a random prescaler, polarity, wrap limit and pulse count, and a bench model of the division and wrap computes the expected count.

// File: rtl/tec_pkg.sv
package tec_pkg;

  typedef enum logic [2:0] {
    SM_OFF   = 3'b000,
    SM_ENC_A = 3'b001,
    SM_ENC_B = 3'b010,
    SM_ENC_C = 3'b011,
    SM_RESET = 3'b100,
    SM_GATED = 3'b101,
    SM_TRIG  = 3'b110,
    SM_EXT1  = 3'b111
  } slave_mode_e;

  localparam logic [1:0] ADDR_MODE = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_ARR  = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  localparam int SM_LSB   = 0;
  localparam int TS_LSB   = 3;
  localparam int EPOL_BIT = 6;
  localparam int PSC_LSB  = 7;
  localparam int ECE_BIT  = 9;
  localparam int TPOL_BIT = 10;
  localparam int MODE_W   = 11;

  // Modes that may not share the counter with external-edge counting.
  function automatic logic mode_blocks_ext(slave_mode_e m);
    return (m == SM_ENC_A) || (m == SM_ENC_B) || (m == SM_ENC_C) || (m == SM_EXT1);
  endfunction

endpackage

// File: rtl/tec_sync_edge.sv
module tec_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic fall_sel,
  output logic edge_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;
  logic              cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign cur    = chain_q[STAGES-1];
  assign edge_o = fall_sel ? (~cur & last_q) : (cur & ~last_q);

  // A detected edge lasts one cycle unless polarity was just changed.
  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    edge_o |=> (!edge_o || !$stable(fall_sel)));
endmodule

// File: rtl/tec_prescaler.sv
module tec_prescaler #(
  parameter int PSC_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             evt,
  input  logic [PSC_W-1:0] code,
  output logic             tick
);
  localparam int DIV_W = (1 << PSC_W) - 1;

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] mask;

  assign mask = DIV_W'((1 << code) - 1);
  assign tick = evt && (cnt_q == mask);

  always_ff @(posedge clk) begin
    if (rst || clr)      cnt_q <= '0;
    else if (tick)       cnt_q <= '0;
    else if (evt)        cnt_q <= cnt_q + 1'b1;
  end

  assert_phase_bound_R7: assert property (@(posedge clk) disable iff (rst)
    $stable(code) |-> (cnt_q <= mask));
  assert_phase_clear_R7: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/tec_core.sv
module tec_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (rst)                cnt_o <= '0;
    else if (run && tick)   cnt_o <= (cnt_o >= limit) ? '0 : cnt_o + 1'b1;
  end

  assert_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    (run && tick && cnt_o >= limit) |=> (cnt_o == '0));
  assert_hold_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(cnt_o));
endmodule

// File: rtl/trig_ext_counter.sv
module trig_ext_counter
  import tec_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int TS_W        = 3,
  parameter int PSC_W       = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_we,
  input  logic [1:0]             cfg_addr,
  input  logic [CNT_W-1:0]       cfg_wdata,
  input  logic                   ext_clk_pin,
  input  logic [(1<<TS_W)-1:0]   trig_pins,
  output logic [CNT_W-1:0]       count_o,
  output logic                   run_o,
  output logic                   trig_flag_o
);
  localparam int N_TRIG = 1 << TS_W;

  logic [MODE_W-1:0] mode_q;
  logic [CNT_W-1:0]  limit_q;
  slave_mode_e       smode;
  logic [TS_W-1:0]   tsel;
  logic [PSC_W-1:0]  psc_code;
  logic              ext_pol, trig_pol, ext_en;
  logic [N_TRIG-1:0] trig_edges;
  logic              ext_edge, psc_tick, cnt_tick, trig_evt;
  logic              wr_mode, wr_ctrl, wr_arr, wr_stat;

  assign smode    = slave_mode_e'(mode_q[SM_LSB +: 3]);
  assign tsel     = mode_q[TS_LSB +: TS_W];
  assign psc_code = mode_q[PSC_LSB +: PSC_W];
  assign ext_pol  = mode_q[EPOL_BIT];
  assign trig_pol = mode_q[TPOL_BIT];
  assign ext_en   = mode_q[ECE_BIT];

  assign wr_mode = cfg_we && (cfg_addr == ADDR_MODE);
  assign wr_ctrl = cfg_we && (cfg_addr == ADDR_CTRL);
  assign wr_arr  = cfg_we && (cfg_addr == ADDR_ARR);
  assign wr_stat = cfg_we && (cfg_addr == ADDR_STAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= '0;
      limit_q <= '1;
    end else begin
      if (wr_mode) mode_q  <= cfg_wdata[MODE_W-1:0];
      if (wr_arr)  limit_q <= cfg_wdata;
    end
  end

  tec_sync_edge #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk(clk), .rst(rst), .pin(ext_clk_pin), .fall_sel(ext_pol), .edge_o(ext_edge)
  );

  for (genvar g = 0; g < N_TRIG; g++) begin : g_trig
    tec_sync_edge #(.STAGES(SYNC_STAGES)) u_trig_sync (
      .clk(clk), .rst(rst), .pin(trig_pins[g]), .fall_sel(trig_pol),
      .edge_o(trig_edges[g])
    );
  end

  assign trig_evt = (smode == SM_TRIG) && trig_edges[tsel];

  always_ff @(posedge clk) begin
    if (rst)            run_o <= 1'b0;
    else if (trig_evt)  run_o <= 1'b1;
    else if (wr_ctrl)   run_o <= cfg_wdata[0];
  end

  always_ff @(posedge clk) begin
    if (rst)                          trig_flag_o <= 1'b0;
    else if (trig_evt)                trig_flag_o <= 1'b1;
    else if (wr_stat && !cfg_wdata[0]) trig_flag_o <= 1'b0;
  end

  tec_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst(rst), .clr(!run_o), .evt(ext_edge && run_o && ext_en),
    .code(psc_code), .tick(psc_tick)
  );

  assign cnt_tick = ext_en ? (psc_tick && !mode_blocks_ext(smode)) : 1'b1;

  tec_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .run(run_o), .tick(cnt_tick), .limit(limit_q),
    .cnt_o(count_o)
  );

  assert_trig_sets_both_R2: assert property (@(posedge clk) disable iff (rst)
    trig_evt |=> (run_o && trig_flag_o));
  assert_flag_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (trig_evt && wr_stat) |=> trig_flag_o);
  assert_run_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    (run_o && !wr_ctrl) |=> run_o);
  assert_blocked_mode_R12: assert property (@(posedge clk) disable iff (rst)
    (ext_en && mode_blocks_ext(smode) && !wr_mode) |=> $stable(count_o));
  assert_other_mode_R5: assert property (@(posedge clk) disable iff (rst)
    (smode != SM_TRIG && !wr_stat && !wr_ctrl) |=>
      ($stable(run_o) && $stable(trig_flag_o)));
endmodule

// File: tb/trig_ext_counter_test.sv
`timescale 1ns/1ps
module trig_ext_counter_test;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_addr = '0;
  logic [CW-1:0] cfg_wdata = '0;
  logic          ext_clk_pin = 1'b0;
  logic [7:0]    trig_pins = '0;
  logic [CW-1:0] count_o;
  logic          run_o, trig_flag_o;

  int checks = 0;
  int errors = 0;
  logic [CW-1:0] exp_cnt = '0;
  logic [CW-1:0] exp_lim = '1;

  always #4 clk = ~clk;

  trig_ext_counter uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ext_clk_pin(ext_clk_pin), .trig_pins(trig_pins),
    .count_o(count_o), .run_o(run_o), .trig_flag_o(trig_flag_o)
  );

  function automatic logic [CW-1:0] step(logic [CW-1:0] c, logic [CW-1:0] lim);
    return (c >= lim) ? '0 : c + 1'b1;
  endfunction

  function automatic logic [CW-1:0] mw(int sm, int ts, int epol, int psc, int ece, int tpol);
    return CW'((sm & 7) | ((ts & 7) << 3) | ((epol & 1) << 6) | ((psc & 3) << 7) |
               ((ece & 1) << 9) | ((tpol & 1) << 10));
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [CW-1:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_limit(logic [CW-1:0] l);
    wr(2'd2, l);
    exp_lim = l;
  endtask

  task automatic advance(int n);
    for (int i = 0; i < n; i++) exp_cnt = step(exp_cnt, exp_lim);
  endtask

  task automatic ext_pulse();
    ext_clk_pin = 1'b1;
    repeat (2) @(negedge clk);
    ext_clk_pin = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 count", count_o, 0);
    check("R1 run", run_o, 0);
    check("R1 flag", trig_flag_o, 0);

    // R9 / R8: system-clock counting with a small wrap limit
    wr(2'd0, mw(0, 0, 0, 0, 0, 0));
    set_limit(10);
    wr(2'd1, 1); repeat (6) @(negedge clk); wr(2'd1, 0); @(negedge clk);
    advance(7);
    check("R9 sysclk count", count_o, exp_cnt);
    wr(2'd1, 1); repeat (8) @(negedge clk); wr(2'd1, 0); @(negedge clk);
    advance(9);
    check("R8 wrap", count_o, exp_cnt);
    repeat (5) @(negedge clk);
    check("R11 hold while stopped", count_o, exp_cnt);

    // trigger mode, select 5, rising
    wr(2'd0, mw(6, 5, 0, 0, 1, 0));
    trig_pins[2] = 1'b1; repeat (4) @(negedge clk);
    check("R3 other pin run", run_o, 0);
    check("R3 other pin flag", trig_flag_o, 0);
    trig_pins[2] = 1'b0; repeat (3) @(negedge clk);
    trig_pins[5] = 1'b1; repeat (2) @(negedge clk);
    check("R2 not early run", run_o, 0);
    check("R2 not early flag", trig_flag_o, 0);
    @(negedge clk);
    check("R2 run", run_o, 1);
    check("R2 flag", trig_flag_o, 1);
    repeat (20) @(negedge clk);
    check("R11 run sticky", run_o, 1);
    check("R6 idle pin no count", count_o, exp_cnt);
    trig_pins[5] = 1'b0;
    wr(2'd1, 0);
    check("R11 run cleared", run_o, 0);
    wr(2'd3, 1);
    check("R10 write 1 keeps", trig_flag_o, 1);
    wr(2'd3, 0);
    check("R10 clear", trig_flag_o, 0);

    // R10 race: clearing write captured on the same edge as the trigger event
    trig_pins[5] = 1'b1; repeat (2) @(negedge clk);
    wr(2'd3, 0);
    check("R10 trigger wins flag", trig_flag_o, 1);
    check("R10 trigger wins run", run_o, 1);
    wr(2'd1, 0); trig_pins[5] = 1'b0; repeat (4) @(negedge clk);
    wr(2'd3, 0);

    // R4 falling trigger polarity
    wr(2'd0, mw(6, 5, 0, 0, 1, 1));
    trig_pins[5] = 1'b1; repeat (4) @(negedge clk);
    check("R4 rising ignored", run_o, 0);
    trig_pins[5] = 1'b0; repeat (2) @(negedge clk);
    check("R4 not early", run_o, 0);
    @(negedge clk);
    check("R4 falling run", run_o, 1);
    check("R4 falling flag", trig_flag_o, 1);
    wr(2'd1, 0); wr(2'd3, 0);

    // R5 other slave modes ignore triggers
    wr(2'd0, mw(0, 5, 0, 0, 1, 0));
    trig_pins[5] = 1'b1; repeat (4) @(negedge clk); trig_pins[5] = 1'b0; repeat (4) @(negedge clk);
    check("R5 off mode run", run_o, 0);
    check("R5 off mode flag", trig_flag_o, 0);
    wr(2'd0, mw(5, 5, 0, 0, 1, 0));
    trig_pins[5] = 1'b1; repeat (4) @(negedge clk); trig_pins[5] = 1'b0; repeat (4) @(negedge clk);
    check("R5 gated code run", run_o, 0);
    check("R5 gated code flag", trig_flag_o, 0);

    // R6 external edge counting and latency
    wr(2'd0, mw(0, 0, 0, 0, 1, 0));
    set_limit(1000);
    wr(2'd1, 1);
    ext_clk_pin = 1'b1; repeat (2) @(negedge clk);
    check("R6 not early", count_o, exp_cnt);
    @(negedge clk); advance(1);
    check("R6 rising counted", count_o, exp_cnt);
    ext_clk_pin = 1'b0; repeat (4) @(negedge clk);
    check("R6 falling ignored", count_o, exp_cnt);
    wr(2'd0, mw(0, 0, 1, 0, 1, 0));
    ext_clk_pin = 1'b1; repeat (4) @(negedge clk);
    check("R6 rising ignored when falling", count_o, exp_cnt);
    ext_clk_pin = 1'b0; repeat (3) @(negedge clk); advance(1);
    check("R6 falling counted", count_o, exp_cnt);

    // R12 blocked mode combinations
    wr(2'd0, mw(7, 0, 0, 0, 1, 0));
    repeat (3) ext_pulse();
    check("R12 code 111 holds", count_o, exp_cnt);
    wr(2'd0, mw(2, 0, 0, 0, 1, 0));
    repeat (3) ext_pulse();
    check("R12 code 010 holds", count_o, exp_cnt);
    wr(2'd1, 0);

    // R7 directed divide by 4
    wr(2'd0, mw(0, 0, 0, 2, 1, 0));
    wr(2'd1, 1);
    repeat (3) ext_pulse(); repeat (3) @(negedge clk);
    check("R7 div4 partial", count_o, exp_cnt);
    ext_pulse(); repeat (3) @(negedge clk); advance(1);
    check("R7 div4 one", count_o, exp_cnt);
    repeat (8) ext_pulse(); repeat (3) @(negedge clk); advance(2);
    check("R7 div4 two more", count_o, exp_cnt);
    wr(2'd1, 0);

    // random rounds: prescaler, polarity, wrap limit, pulse count
    for (int r = 0; r < 16; r++) begin
      int psc, pol, n;
      logic [CW-1:0] lim;
      psc = int'($urandom % 4);
      pol = int'($urandom % 2);
      n   = int'($urandom % 40);
      lim = CW'(2 + ($urandom % 30));
      set_limit(lim);
      wr(2'd0, mw(0, 0, pol, psc, 1, 0));
      wr(2'd1, 1);
      for (int k = 0; k < n; k++) ext_pulse();
      repeat (3) @(negedge clk);
      wr(2'd1, 0);
      advance(n / (1 << psc));
      check("R7 R8 random round", count_o, exp_cnt);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule